// File: doc/BRIEF.md
# Multi-channel level and edge trigger matcher

The matcher watches a bank of logic-analyser input channels and decides, on every sample strobe, whether the sampled word meets a configured trigger condition. When it does, the matcher emits a one-cycle hit pulse and disarms. Software re-arms it for the next capture.

The trigger condition comes from four configuration words. Each word is 32 bits wide. A write index selects which word is being loaded:

- index 0 marks which channels are in use;
- index 1 enables a channel for triggering;
- index 2 picks level or edge sense per channel;
- index 3 picks the polarity.

A channel takes part in the trigger only when it is both in use and enabled.

Level channels are compared with the current sample. Edge channels compare the current sample with the sample from the previous strobe. At most one participating channel may use edge sense. Any number of level channels can be combined with that one edge channel, and all of them must agree on the same sample.

If the configuration asks for two or more edge channels, an error flag rises and the matcher never fires. Arming clears the edge history, so the first strobe after arming only records a reference sample for edge channels.

Top module: `trig_matcher`

## Requirements
- R1: After reset, hit_o, armed_o and cfg_err_o are 0 and all four configuration words are zero.
- R2: A write with cfg_we_i=1 loads cfg_data_i into the word selected by cfg_idx_i. The encoding is 0 = in-use, 1 = enable, 2 = level select, 3 = polarity. Bit i of each word belongs to channel i, and bits at or above NUM_CH are ignored. A channel participates only when its in-use and enable bits are both 1.
- R3: A participating channel whose level bit is 1 is satisfied when its sample bit equals its polarity bit (1 = high, 0 = low).
- R4: A participating channel whose level bit is 0 is edge-sensitive. Polarity 0 is satisfied by a rising edge (previous strobe sample 0, current 1). Polarity 1 is satisfied by a falling edge (previous 1, current 0).
- R5: A hit is evaluated only on a cycle with strobe_i=1 while armed. It requires every participating channel to be satisfied on that sample. hit_o is 1 for exactly the cycle after that strobe.
- R6: With no participating channel, the first strobe after arming produces a hit.
- R7: When two or more participating channels are edge-sensitive, cfg_err_o is 1 from the cycle after the offending write, and no hit is produced.
- R8: On the first strobe after arming, edge conditions are never satisfied; that strobe only records the reference sample.
- R9: A hit clears armed_o. Further strobes produce no hit until arm_i is asserted again.
- R10: In a cycle with arm_i=1, any strobe is ignored. armed_o is 1 in the following cycle.
- R11: The edge reference is updated only on strobe cycles. Sample changes between strobes neither create nor hide an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Configuration word select (0 in-use, 1 enable, 2 level, 3 polarity) |
| cfg_data_i | input | 32 | Configuration word data |
| arm_i | input | 1 | Arm request; clears edge history |
| strobe_i | input | 1 | Sample valid strobe |
| sample_i | input | NUM_CH | Sampled channel levels |
| hit_o | output | 1 | One-cycle trigger hit pulse |
| armed_o | output | 1 | Matcher is armed |
| cfg_err_o | output | 1 | More than one edge channel configured |

## Verification
The properties assume that arm_i and strobe_i are single-cycle, synchronous pulses. They also assume that configuration writes are settled before the strobes that depend on them.

Because of this, the ordering properties only reason about the cycle directly before a hit. The stimulus issues every configuration write and every arm in a cycle of its own, ahead of the strobes of each trial. The only exception is one deliberate trial that raises arm and strobe together.

A further assumption concerns the error flag: any configuration error has to be visible for a cycle before a strobe. The stimulus keeps to this by never changing the configuration in a strobe cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned CFG_W = 32;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    CFG_INUSE  = 2'd0,
    CFG_ENABLE = 2'd1,
    CFG_LEVEL  = 2'd2,
    CFG_POLAR  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [CFG_W-1:0]     data_i,
  output logic [NUM_CH-1:0]    part_o,
  output logic [NUM_CH-1:0]    lvl_o,
  output logic [NUM_CH-1:0]    pol_o,
  output logic                 err_o
);
  localparam int unsigned CNT_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0] inuse_q, en_q, lvl_q, pol_q;
  logic [NUM_CH-1:0] wdata;
  logic [NUM_CH-1:0] edge_sel;
  logic [CNT_W-1:0]  edge_cnt;

  assign wdata = data_i[NUM_CH-1:0];

  generate
    if (NUM_CH < CFG_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^data_i[CFG_W-1:NUM_CH];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inuse_q <= '0;
      en_q    <= '0;
      lvl_q   <= '0;
      pol_q   <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(idx_i))
        CFG_INUSE:  inuse_q <= wdata;
        CFG_ENABLE: en_q    <= wdata;
        CFG_LEVEL:  lvl_q   <= wdata;
        CFG_POLAR:  pol_q   <= wdata;
        default:    ;
      endcase
    end
  end

  assign part_o   = inuse_q & en_q;
  assign lvl_o    = lvl_q;
  assign pol_o    = pol_q;
  assign edge_sel = part_o & ~lvl_q;

  always_comb begin
    edge_cnt = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      edge_cnt = edge_cnt + CNT_W'(edge_sel[i]);
    end
  end

  assign err_o = (edge_cnt > CNT_W'(1));
endmodule

// File: rtl/trig_hist.sv
module trig_hist #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              strobe_i,
  input  logic [NUM_CH-1:0] sample_i,
  output logic [NUM_CH-1:0] prev_o,
  output logic              primed_o
);
  logic [NUM_CH-1:0] prev_q;
  logic              primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (arm_i) begin
      primed_q <= 1'b0;
    end else if (strobe_i) begin
      prev_q   <= sample_i;
      primed_q <= 1'b1;
    end
  end

  assign prev_o   = prev_q;
  assign primed_o = primed_q;
endmodule

// File: rtl/trig_lane.sv
module trig_lane (
  input  logic part_i,
  input  logic lvl_i,
  input  logic pol_i,
  input  logic cur_i,
  input  logic prev_i,
  input  logic primed_i,
  output logic ok_o
);
  logic lvl_ok, edge_ok;

  assign lvl_ok  = (cur_i == pol_i);
  // pol 0 rising, pol 1 falling
  assign edge_ok = primed_i & (prev_i == pol_i) & (cur_i != pol_i);
  assign ok_o    = ~part_i | (lvl_i ? lvl_ok : edge_ok);
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
  import trig_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_idx_i,
  input  logic [31:0]       cfg_data_i,
  input  logic              arm_i,
  input  logic              strobe_i,
  input  logic [NUM_CH-1:0] sample_i,
  output logic              hit_o,
  output logic              armed_o,
  output logic              cfg_err_o
);
  logic [NUM_CH-1:0] part, lvl, pol, prev, lane_ok;
  logic              primed, err, match;
  logic              armed_q, hit_q;

  trig_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .data_i (cfg_data_i),
    .part_o (part),
    .lvl_o  (lvl),
    .pol_o  (pol),
    .err_o  (err)
  );

  trig_hist #(.NUM_CH(NUM_CH)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .strobe_i (strobe_i),
    .sample_i (sample_i),
    .prev_o   (prev),
    .primed_o (primed)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      trig_lane u_lane (
        .part_i   (part[g]),
        .lvl_i    (lvl[g]),
        .pol_i    (pol[g]),
        .cur_i    (sample_i[g]),
        .prev_i   (prev[g]),
        .primed_i (primed),
        .ok_o     (lane_ok[g])
      );
    end
  endgenerate

  assign match = (&lane_ok) & ~err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      hit_q   <= 1'b0;
    end else if (strobe_i && armed_q && match) begin
      armed_q <= 1'b0;
      hit_q   <= 1'b1;
    end else begin
      hit_q   <= 1'b0;
    end
  end

  assign hit_o     = hit_q;
  assign armed_o   = armed_q;
  assign cfg_err_o = err;
endmodule

// File: rtl/trig_matcher_chk.sv
module trig_matcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic arm_i,
  input logic strobe_i,
  input logic hit_o,
  input logic armed_o,
  input logic cfg_err_o
);
  // R5
  hit_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(strobe_i && armed_o && !arm_i));

  // R9
  hit_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !armed_o);

  // R5
  hit_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

  // R7
  no_hit_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_err_o) |-> !hit_o);

  // R10
  arm_blocks_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(arm_i) |-> (armed_o && !hit_o));
endmodule

bind trig_matcher trig_matcher_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_i     (arm_i),
  .strobe_i  (strobe_i),
  .hit_o     (hit_o),
  .armed_o   (armed_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/trig_matcher_tb_top.sv
`timescale 1ns/1ps
module trig_matcher_tb_top;
  localparam int unsigned N = 4;
  localparam int unsigned MAXC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] idx = '0;
  logic [31:0] data = '0;
  logic arm = 1'b0;
  logic stb = 1'b0;
  logic [N-1:0] smp = '0;
  logic hit, armed, err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_matcher #(.NUM_CH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_data_i(data), .arm_i(arm), .strobe_i(stb), .sample_i(smp),
    .hit_o(hit), .armed_o(armed), .cfg_err_o(err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] i, input logic [31:0] d);
    we = 1'b1; idx = i; data = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] u, input logic [31:0] e,
                     input logic [31:0] l, input logic [31:0] p);
    wr(2'd0, u); wr(2'd1, e); wr(2'd2, l); wr(2'd3, p);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic strobe(input logic [N-1:0] s);
    smp = s; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (MAXC) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_tb();
  end

  initial begin
    logic [N-1:0] part, lv, pl;
    logic exp;
    @(negedge clk); @(negedge clk);
    // R1
    chk("R1 hit", hit, 1'b0);
    chk("R1 armed", armed, 1'b0);
    chk("R1 err", err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hit after release", hit, 1'b0);
    // R1: zero config means nothing participates -> first strobe hits (R6)
    do_arm();
    strobe(4'h0);
    chk("R1 zero cfg hit", hit, 1'b1);

    // R2 R3 R5 R6: level-only sweep over in-use, enable, polarity, sample
    for (int ci = 0; ci < 2; ci++) begin
      for (int e = 0; e < 16; e++) begin
        for (int p = 0; p < 16; p++) begin
          logic [31:0] u;
          u = (ci == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFF5; // upper bits ignored (R2)
          cfg(u, 32'hA5A5_A5A0 | 32'(e), 32'hFFFF_FFFF, 32'h5A5A_5A50 | 32'(p));
          chk("R7 level-only err", err, 1'b0);
          part = u[N-1:0] & 4'(e);
          for (int s = 0; s < 16; s++) begin
            do_arm();
            strobe(4'(s));
            exp = ((~(4'(s) ^ 4'(p)) & part) == part);
            chk(part == 0 ? "R6 empty fires" : "R3 R2 R5 level hit", hit, exp);
          end
        end
      end
    end

    // R4 R8: one edge channel with level channels
    for (int ec = 0; ec < N; ec++) begin
      for (int pe = 0; pe < 2; pe++) begin
        for (int li = 0; li < 2; li++) begin
          logic [N-1:0] lp;
          lp = (li == 0) ? 4'h0 : 4'hF;
          lv = 4'hF & ~(4'b1 << ec);
          pl = (lp & lv) | (4'(pe) << ec);
          cfg(32'hF, 32'hF, 32'(lv), 32'(pl));
          chk("R7 one edge no err", err, 1'b0);
          for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
              logic pb, cb, eok, lok;
              do_arm();
              strobe(4'(a));
              chk("R8 first strobe no edge", hit, 1'b0);
              strobe(4'(b));
              pb = a[ec]; cb = b[ec];
              eok = pe ? (pb & ~cb) : (~pb & cb);
              lok = ((~(4'(b) ^ lp) & lv) == lv);
              chk("R4 edge hit", hit, eok & lok);
            end
          end
        end
      end
    end

    // R7: two edge channels
    cfg(32'hF, 32'h3, 32'hC, 32'h0);
    chk("R7 err raised", err, 1'b1);
    do_arm();
    strobe(4'h0);
    strobe(4'h3);
    chk("R7 no hit", hit, 1'b0);
    strobe(4'h0);
    strobe(4'h3);
    chk("R7 no hit again", hit, 1'b0);
    chk("R7 still armed", armed, 1'b1);
    // dropping a channel clears it
    wr(2'd1, 32'h1);
    chk("R7 err cleared", err, 1'b0);

    // R9: after a hit, further strobes ignored until re-armed
    cfg(32'hF, 32'h1, 32'h1, 32'h1);
    do_arm();
    chk("R9 armed", armed, 1'b1);
    strobe(4'h1);
    chk("R9 hit", hit, 1'b1);
    chk("R9 disarmed", armed, 1'b0);
    strobe(4'h1);
    chk("R9 no rehit", hit, 1'b0);
    do_arm();
    strobe(4'h1);
    chk("R9 rearm hit", hit, 1'b1);

    // R10: strobe in arm cycle ignored
    arm = 1'b1; smp = 4'h1; stb = 1'b1;
    @(negedge clk);
    arm = 1'b0; stb = 1'b0;
    chk("R10 no hit in arm cycle", hit, 1'b0);
    chk("R10 armed", armed, 1'b1);
    strobe(4'h1);
    chk("R10 next strobe hits", hit, 1'b1);

    // R11: sample changes between strobes do not move the reference
    cfg(32'hF, 32'h2, 32'h0, 32'h0);
    do_arm();
    strobe(4'h0);
    smp = 4'h2; @(negedge clk);
    chk("R11 no hit without strobe", hit, 1'b0);
    smp = 4'h0; @(negedge clk);
    strobe(4'h2);
    chk("R11 edge vs last strobe", hit, 1'b1);
    do_arm();
    strobe(4'h0);
    smp = 4'h2; @(negedge clk);
    strobe(4'h0);
    chk("R11 no hidden edge", hit, 1'b0);

    finish_tb();
  end
endmodule